// File: doc/BRIEF.md
# Display Power-Management Sync Gating Unit

This unit sits between a display timing generator and the monitor connector. It holds the host-visible control bits that put the display into one of four power states, and it applies them to the raw horizontal sync, vertical sync and video-enable signals coming out of the timing generator. Each sync can be suppressed on its own, and a separate bit blanks the picture. A suppressed sync is driven to its inactive level rather than frozen.

The host reaches the control bits through two indexed register pairs: a fixed sequencer pair at I/O addresses 0x3C4 (index) and 0x3C5 (data), and a relocatable CRTC pair at `io_base + 4` (index) and `io_base + 5` (data). A write to an index port selects a register, and a following data-port access reads or writes it. A built-in mode encoder accepts a power-mode code and performs the required read-modify-write accesses through the same register path. Only the power-management bits change; every other bit in those registers keeps its value.

Top module: `dpms_sync_ctrl`

## Requirements
- R1: After reset all index and data registers are zero, `hsync_out` and `vsync_out` are at their inactive level, `video_en_out` is 0, `pm_busy` is 0 and `bus_rdata` is 0.
- R2: Bit 5 of sequencer register 0x01 blanks the screen. While it is 1, `video_en_out` is 0. While it is 0, `video_en_out` follows `tg_video_en`.
- R3: Bit 0 of CRTC register 0x34 disables horizontal sync. While it is 1, `hsync_out` is held at the inactive level (the inverse of `HS_ACTIVE`) whatever `tg_hsync` does.
- R4: Bit 5 of CRTC register 0x34 disables vertical sync. While it is 1, `vsync_out` is held at the inactive level (the inverse of `VS_ACTIVE`).
- R5: All three display outputs are registered. A change on a `tg_*` input or on a control bit appears at the output exactly one clock later.
- R6: A read of a data port returns the register selected by its index port. A read of an index port returns that index. A data-port access to any index other than 0x01 (sequencer) or 0x34 (CRTC) reads 0, and a write to it is ignored. Read data appears on `bus_rdata` one clock after `bus_rd` and is held until the next accepted read.
- R7: A `pm_req` pulse applies the mode in `pm_mode`. The codes are:
  - 0 (On): both syncs on, screen on.
  - 1 (Standby): hsync off, vsync on, screen blanked.
  - 2 (Suspend): hsync on, vsync off, screen blanked.
  - 3 (Off): both syncs off, screen blanked.
- R8: Any `pm_mode` code above 3 is applied as On.
- R9: A mode change writes only bit 5 of sequencer register 0x01 and bits 0 and 5 of CRTC register 0x34. All other bits of both registers keep their previous values.
- R10: `pm_busy` is high for exactly 4 cycles after an accepted `pm_req`. After a mode change, the sequencer index reads 0x01 and the CRTC index reads 0x34.
- R11: While `pm_busy` is high, host reads, host writes and new `pm_req` pulses are ignored.
- R12: The CRTC ports move with `io_base`. A host access to an address that matches none of the four ports reads 0 and changes nothing. The sequencer decode takes priority where the two overlap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_base | input | ADDR_W | Base address of the CRTC index/data pair |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid the cycle after `bus_rd` |
| pm_req | input | 1 | Start a power-mode change |
| pm_mode | input | MODE_W | Requested power-mode code |
| pm_busy | output | 1 | Mode encoder is performing its accesses |
| tg_hsync | input | 1 | Raw horizontal sync from the timing generator |
| tg_vsync | input | 1 | Raw vertical sync from the timing generator |
| tg_video_en | input | 1 | Raw video enable from the timing generator |
| hsync_out | output | 1 | Gated horizontal sync |
| vsync_out | output | 1 | Gated vertical sync |
| video_en_out | output | 1 | Video enable after blanking |

## Verification
The hardest case to reach is a mode change that has to preserve unrelated bits. It only means something once both target registers hold non-zero patterns in their other bits and the index registers point somewhere else. The stimulus therefore preloads those patterns through the host ports and moves both indices away. It then steps through every mode code, including codes above 3. After each change it reads both registers and both indices back through the ports. Host writes and a second request are fired while the encoder is busy, so the bench can show that they leave no trace.

// File: rtl/dpms_pkg.sv
package dpms_pkg;

    localparam int REG_W    = 8;
    localparam int PM_STEPS = 4;

    localparam logic [15:0] SEQ_IDX_PORT = 16'h03C4;
    localparam logic [15:0] SEQ_DAT_PORT = 16'h03C5;
    localparam logic [15:0] CRT_IDX_OFS  = 16'h0004;
    localparam logic [15:0] CRT_DAT_OFS  = 16'h0005;

    localparam logic [REG_W-1:0] SEQ_BLANK_IDX = 8'h01;
    localparam logic [REG_W-1:0] CRT_SYNC_IDX  = 8'h34;

    localparam logic [REG_W-1:0] SEQ_BLANK_MASK = 8'h20;
    localparam logic [REG_W-1:0] CRT_HS_MASK    = 8'h01;
    localparam logic [REG_W-1:0] CRT_VS_MASK    = 8'h20;

    typedef enum logic [2:0] {
        PORT_NONE,
        PORT_SEQ_IDX,
        PORT_SEQ_DAT,
        PORT_CRT_IDX,
        PORT_CRT_DAT
    } port_e;

    typedef enum logic [1:0] {
        PM_ON      = 2'd0,
        PM_STANDBY = 2'd1,
        PM_SUSPEND = 2'd2,
        PM_OFF     = 2'd3
    } pm_mode_e;

    typedef struct packed {
        logic blank;
        logic hs_off;
        logic vs_off;
    } pm_ctl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEQ_IDX,
        ST_SEQ_DAT,
        ST_CRT_IDX,
        ST_CRT_DAT
    } enc_st_e;

    function automatic pm_ctl_t mode_ctl(input logic [7:0] code);
        pm_ctl_t c;
        c = '0;
        if (code < 8'd4) begin
            case (pm_mode_e'(code[1:0]))
                PM_STANDBY: c = '{blank: 1'b1, hs_off: 1'b1, vs_off: 1'b0};
                PM_SUSPEND: c = '{blank: 1'b1, hs_off: 1'b0, vs_off: 1'b1};
                PM_OFF:     c = '{blank: 1'b1, hs_off: 1'b1, vs_off: 1'b1};
                default:    c = '0;
            endcase
        end
        return c;
    endfunction

    function automatic logic [REG_W-1:0] rmw(input logic [REG_W-1:0] old_v,
                                             input logic [REG_W-1:0] mask,
                                             input logic [REG_W-1:0] bits);
        return (old_v & ~mask) | (bits & mask);
    endfunction

endpackage

// File: rtl/dpms_port_decode.sv
module dpms_port_decode
    import dpms_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] io_base,
    output port_e             port
);
    logic [ADDR_W-1:0] crt_idx_a;
    logic [ADDR_W-1:0] crt_dat_a;

    assign crt_idx_a = io_base + ADDR_W'(CRT_IDX_OFS);
    assign crt_dat_a = io_base + ADDR_W'(CRT_DAT_OFS);

    always_comb begin
        if (addr == ADDR_W'(SEQ_IDX_PORT))      port = PORT_SEQ_IDX;
        else if (addr == ADDR_W'(SEQ_DAT_PORT)) port = PORT_SEQ_DAT;
        else if (addr == crt_idx_a)             port = PORT_CRT_IDX;
        else if (addr == crt_dat_a)             port = PORT_CRT_DAT;
        else                                    port = PORT_NONE;
    end
endmodule

// File: rtl/dpms_regfile.sv
module dpms_regfile
    import dpms_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_wr,
    input  port_e            op_port,
    input  logic [REG_W-1:0] op_wdata,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] seq_reg,
    output logic [REG_W-1:0] crt_reg
);
    logic [REG_W-1:0] seq_idx;
    logic [REG_W-1:0] crt_idx;
    logic             seq_hit;
    logic             crt_hit;

    assign seq_hit = (seq_idx == SEQ_BLANK_IDX);
    assign crt_hit = (crt_idx == CRT_SYNC_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_idx <= '0;
            crt_idx <= '0;
            seq_reg <= '0;
            crt_reg <= '0;
        end else if (op_wr) begin
            case (op_port)
                PORT_SEQ_IDX: seq_idx <= op_wdata;
                PORT_SEQ_DAT: if (seq_hit) seq_reg <= op_wdata;
                PORT_CRT_IDX: crt_idx <= op_wdata;
                PORT_CRT_DAT: if (crt_hit) crt_reg <= op_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (op_port)
            PORT_SEQ_IDX: rd_data = seq_idx;
            PORT_SEQ_DAT: rd_data = seq_hit ? seq_reg : '0;
            PORT_CRT_IDX: rd_data = crt_idx;
            PORT_CRT_DAT: rd_data = crt_hit ? crt_reg : '0;
            default:      rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dpms_mode_enc.sv
module dpms_mode_enc
    import dpms_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [MODE_W-1:0] mode,
    input  logic [REG_W-1:0]  rd_data,
    output logic              busy,
    output logic              enc_wr,
    output port_e             enc_port,
    output logic [REG_W-1:0]  enc_wdata
);
    enc_st_e    st;
    pm_ctl_t    ctl_q;
    logic [7:0] code_ext;
    logic [REG_W-1:0] crt_bits;

    always_comb begin
        code_ext = '0;
        code_ext[MODE_W-1:0] = mode;
    end

    assign busy     = (st != ST_IDLE);
    assign crt_bits = (ctl_q.hs_off ? CRT_HS_MASK : '0) | (ctl_q.vs_off ? CRT_VS_MASK : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            ctl_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req) begin
                    ctl_q <= mode_ctl(code_ext);
                    st    <= ST_SEQ_IDX;
                end
                ST_SEQ_IDX: st <= ST_SEQ_DAT;
                ST_SEQ_DAT: st <= ST_CRT_IDX;
                ST_CRT_IDX: st <= ST_CRT_DAT;
                default:    st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        enc_wr    = busy;
        enc_port  = PORT_NONE;
        enc_wdata = '0;
        case (st)
            ST_SEQ_IDX: begin
                enc_port  = PORT_SEQ_IDX;
                enc_wdata = SEQ_BLANK_IDX;
            end
            ST_SEQ_DAT: begin
                enc_port  = PORT_SEQ_DAT;
                enc_wdata = rmw(rd_data, SEQ_BLANK_MASK, ctl_q.blank ? SEQ_BLANK_MASK : '0);
            end
            ST_CRT_IDX: begin
                enc_port  = PORT_CRT_IDX;
                enc_wdata = CRT_SYNC_IDX;
            end
            ST_CRT_DAT: begin
                enc_port  = PORT_CRT_DAT;
                enc_wdata = rmw(rd_data, CRT_HS_MASK | CRT_VS_MASK, crt_bits);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dpms_sync_gate.sv
module dpms_sync_gate
    import dpms_pkg::*;
#(
    parameter logic HS_ACTIVE = 1'b0,
    parameter logic VS_ACTIVE = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  pm_ctl_t ctl,
    input  logic    tg_hsync,
    input  logic    tg_vsync,
    input  logic    tg_video_en,
    output logic    hsync_out,
    output logic    vsync_out,
    output logic    video_en_out
);
    localparam int          NSYNC = 2;
    localparam logic [1:0]  ACT   = {VS_ACTIVE, HS_ACTIVE};

    logic [NSYNC-1:0] raw;
    logic [NSYNC-1:0] off;
    logic [NSYNC-1:0] sync_q;

    assign raw = {tg_vsync, tg_hsync};
    assign off = {ctl.vs_off, ctl.hs_off};

    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst)         sync_q[g] <= ~ACT[g];
            else if (off[g]) sync_q[g] <= ~ACT[g];
            else             sync_q[g] <= raw[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) video_en_out <= 1'b0;
        else     video_en_out <= tg_video_en & ~ctl.blank;
    end

    assign hsync_out = sync_q[0];
    assign vsync_out = sync_q[1];
endmodule

// File: rtl/dpms_sync_ctrl.sv
module dpms_sync_ctrl
    import dpms_pkg::*;
#(
    parameter int   ADDR_W    = 16,
    parameter int   MODE_W    = 3,
    parameter logic HS_ACTIVE = 1'b0,
    parameter logic VS_ACTIVE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_base,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              pm_req,
    input  logic [MODE_W-1:0] pm_mode,
    output logic              pm_busy,
    input  logic              tg_hsync,
    input  logic              tg_vsync,
    input  logic              tg_video_en,
    output logic              hsync_out,
    output logic              vsync_out,
    output logic              video_en_out
);
    port_e            host_port;
    port_e            enc_port;
    port_e            op_port;
    logic             enc_wr;
    logic             op_wr;
    logic [REG_W-1:0] enc_wdata;
    logic [REG_W-1:0] op_wdata;
    logic [REG_W-1:0] rd_data;
    logic [REG_W-1:0] seq_reg_w;
    logic [REG_W-1:0] crt_reg_w;
    pm_ctl_t          ctl;

    dpms_port_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .io_base (io_base),
        .port    (host_port)
    );

    assign op_wr    = pm_busy ? enc_wr    : bus_wr;
    assign op_port  = pm_busy ? enc_port  : host_port;
    assign op_wdata = pm_busy ? enc_wdata : bus_wdata;

    dpms_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .op_wr    (op_wr),
        .op_port  (op_port),
        .op_wdata (op_wdata),
        .rd_data  (rd_data),
        .seq_reg  (seq_reg_w),
        .crt_reg  (crt_reg_w)
    );

    dpms_mode_enc #(.MODE_W(MODE_W)) u_enc (
        .clk       (clk),
        .rst       (rst),
        .req       (pm_req),
        .mode      (pm_mode),
        .rd_data   (rd_data),
        .busy      (pm_busy),
        .enc_wr    (enc_wr),
        .enc_port  (enc_port),
        .enc_wdata (enc_wdata)
    );

    assign ctl.blank  = |(seq_reg_w & SEQ_BLANK_MASK);
    assign ctl.hs_off = |(crt_reg_w & CRT_HS_MASK);
    assign ctl.vs_off = |(crt_reg_w & CRT_VS_MASK);

    dpms_sync_gate #(.HS_ACTIVE(HS_ACTIVE), .VS_ACTIVE(VS_ACTIVE)) u_gate (
        .clk          (clk),
        .rst          (rst),
        .ctl          (ctl),
        .tg_hsync     (tg_hsync),
        .tg_vsync     (tg_vsync),
        .tg_video_en  (tg_video_en),
        .hsync_out    (hsync_out),
        .vsync_out    (vsync_out),
        .video_en_out (video_en_out)
    );

    always_ff @(posedge clk) begin
        if (rst)                   bus_rdata <= '0;
        else if (bus_rd && !pm_busy) bus_rdata <= rd_data;
    end
endmodule

// File: rtl/dpms_sync_ctrl_chk.sv
module dpms_sync_ctrl_chk
    import dpms_pkg::*;
#(
    parameter logic HS_ACTIVE = 1'b0,
    parameter logic VS_ACTIVE = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       pm_busy,
    input logic [7:0] seq_reg,
    input logic [7:0] crt_reg,
    input logic       hsync_out,
    input logic       vsync_out,
    input logic       video_en_out
);
    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)          run_q <= '0;
        else if (pm_busy) run_q <= run_q + 4'd1;
        else              run_q <= '0;
    end

    a_r2_blank_forces_off: assert property (@(posedge clk) disable iff (rst)
        seq_reg[5] |=> !video_en_out);

    a_r3_hsync_held: assert property (@(posedge clk) disable iff (rst)
        crt_reg[0] |=> (hsync_out == ~HS_ACTIVE));

    a_r4_vsync_held: assert property (@(posedge clk) disable iff (rst)
        crt_reg[5] |=> (vsync_out == ~VS_ACTIVE));

    a_r9_seq_other_bits_kept: assert property (@(posedge clk) disable iff (rst)
        (pm_busy && $past(pm_busy)) |-> ((seq_reg & ~SEQ_BLANK_MASK) == ($past(seq_reg) & ~SEQ_BLANK_MASK)));

    a_r9_crt_other_bits_kept: assert property (@(posedge clk) disable iff (rst)
        (pm_busy && $past(pm_busy)) |->
        ((crt_reg & ~(CRT_HS_MASK | CRT_VS_MASK)) == ($past(crt_reg) & ~(CRT_HS_MASK | CRT_VS_MASK))));

    a_r10_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(pm_busy) |-> (run_q == 4'(PM_STEPS)));
endmodule

bind dpms_sync_ctrl dpms_sync_ctrl_chk #(.HS_ACTIVE(HS_ACTIVE), .VS_ACTIVE(VS_ACTIVE)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pm_busy      (pm_busy),
    .seq_reg      (seq_reg_w),
    .crt_reg      (crt_reg_w),
    .hsync_out    (hsync_out),
    .vsync_out    (vsync_out),
    .video_en_out (video_en_out)
);

// File: tb/test_dpms_sync_ctrl.sv
`timescale 1ns/1ps
module test_dpms_sync_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_base = 16'h03D0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        pm_req = 1'b0;
    logic [2:0]  pm_mode = '0;
    logic        pm_busy;
    logic        tg_hsync = 1'b1;
    logic        tg_vsync = 1'b1;
    logic        tg_video_en = 1'b0;
    logic        hsync_out, vsync_out, video_en_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dpms_sync_ctrl i_dpms_sync_ctrl (
        .clk(clk), .rst(rst), .io_base(io_base), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pm_req(pm_req), .pm_mode(pm_mode), .pm_busy(pm_busy),
        .tg_hsync(tg_hsync), .tg_vsync(tg_vsync), .tg_video_en(tg_video_en),
        .hsync_out(hsync_out), .vsync_out(vsync_out), .video_en_out(video_en_out)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_sidx, m_sreg, m_cidx, m_creg;
    int opq[$];
    int e_hs = 1, e_vs = 1, e_vid = 0, e_busy = 0, e_rdata = 0;
    bit model_on = 0;

    function automatic int m_read(input int a);
        if (a == 'h3C4) return m_sidx;
        if (a == 'h3C5) return (m_sidx == 1) ? m_sreg : 0;
        if (a == int'(io_base) + 4) return m_cidx;
        if (a == int'(io_base) + 5) return (m_cidx == 'h34) ? m_creg : 0;
        return 0;
    endfunction

    function automatic void m_write(input int a, input int d);
        if (a == 'h3C4) m_sidx = d;
        else if (a == 'h3C5) begin if (m_sidx == 1) m_sreg = d; end
        else if (a == int'(io_base) + 4) m_cidx = d;
        else if (a == int'(io_base) + 5) begin if (m_cidx == 'h34) m_creg = d; end
    endfunction

    function automatic void m_apply(input int op);
        int kind = op / 16;
        int md = op % 16;
        bit bl, hs, vs;
        bl = (md >= 1 && md <= 3);
        hs = (md == 1 || md == 3);
        vs = (md == 2 || md == 3);
        case (kind)
            0: m_sidx = 1;
            1: m_sreg = (m_sreg & 'hDF) | (bl ? 'h20 : 0);
            2: m_cidx = 'h34;
            default: m_creg = (m_creg & 'hDE) | (hs ? 'h01 : 0) | (vs ? 'h20 : 0);
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sidx = 0; m_sreg = 0; m_cidx = 0; m_creg = 0;
            opq.delete();
            e_hs = 1; e_vs = 1; e_vid = 0; e_busy = 0; e_rdata = 0;
        end else begin
            e_hs  = m_creg[0] ? 1 : int'(tg_hsync);
            e_vs  = m_creg[5] ? 1 : int'(tg_vsync);
            e_vid = (tg_video_en && !m_sreg[5]) ? 1 : 0;
            if (opq.size() > 0) begin
                m_apply(opq.pop_front());
            end else begin
                if (bus_rd) e_rdata = m_read(int'(bus_addr));
                if (bus_wr) m_write(int'(bus_addr), int'(bus_wdata));
                if (pm_req) for (int k = 0; k < 4; k++) opq.push_back(k * 16 + int'(pm_mode));
            end
            e_busy = (opq.size() > 0) ? 1 : 0;
        end
        model_on = 1;
    end

    always @(negedge clk) begin
        if (model_on && !done) begin
            chk("R3 hsync_out", int'(hsync_out), e_hs);
            chk("R4 vsync_out", int'(vsync_out), e_vs);
            chk("R2 video_en_out", int'(video_en_out), e_vid);
            chk("R10 pm_busy", int'(pm_busy), e_busy);
            chk("R6 bus_rdata", int'(bus_rdata), e_rdata);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic host_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [15:0] a, output int d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = int'(bus_rdata);
    endtask

    task automatic set_mode(input logic [2:0] m, output int busy_cycles);
        @(negedge clk);
        pm_mode = m; pm_req = 1'b1;
        @(negedge clk);
        pm_req = 1'b0;
        busy_cycles = 0;
        while (pm_busy) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    task automatic read_pair(output int s, output int c);
        host_wr(16'h03C4, 8'h01);
        host_rd(16'h03C5, s);
        host_wr(io_base + 16'd4, 8'h34);
        host_rd(io_base + 16'd5, c);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int d, s, c, n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 hsync_out reset", int'(hsync_out), 1);
        chk("R1 vsync_out reset", int'(vsync_out), 1);
        chk("R1 video_en_out reset", int'(video_en_out), 0);
        chk("R1 pm_busy reset", int'(pm_busy), 0);
        chk("R1 bus_rdata reset", int'(bus_rdata), 0);
        rst = 1'b0;
        tg_video_en = 1'b1;
        @(negedge clk);

        // R6 indexed access and read-back
        host_wr(16'h03C4, 8'h01);
        host_rd(16'h03C4, d); chk("R6 seq index read", d, 'h01);
        host_wr(16'h03C5, 8'h5A);
        host_rd(16'h03C5, d); chk("R6 seq data read", d, 'h5A);
        host_wr(16'h03C4, 8'h07);
        host_rd(16'h03C5, d); chk("R6 unimplemented index reads 0", d, 0);
        host_wr(16'h03C5, 8'hFF);
        host_wr(16'h03C4, 8'h01);
        host_rd(16'h03C5, d); chk("R6 unimplemented write ignored", d, 'h5A);

        // R2 blank bit
        chk("R2 video on with bit5 clear", int'(video_en_out), 1);
        host_wr(16'h03C5, 8'h7A);
        @(negedge clk);
        chk("R2 video blanked", int'(video_en_out), 0);
        host_wr(16'h03C5, 8'h5A);
        @(negedge clk);

        // R5 one-cycle latency
        tg_hsync = 1'b0;
        chk("R5 hsync before edge", int'(hsync_out), 1);
        @(negedge clk);
        chk("R5 hsync one cycle later", int'(hsync_out), 0);
        tg_hsync = 1'b1;

        // R3 / R4 sync disables
        host_wr(16'h03D4, 8'h34);
        host_wr(16'h03D5, 8'h01);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); tg_hsync = ~tg_hsync;
            @(negedge clk); chk("R3 hsync held inactive", int'(hsync_out), 1);
        end
        tg_hsync = 1'b1;
        host_wr(16'h03D5, 8'h20);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); tg_vsync = 1'b0; tg_hsync = ~tg_hsync;
            @(negedge clk); chk("R4 vsync held inactive", int'(vsync_out), 1);
        end
        tg_vsync = 1'b1; tg_hsync = 1'b1;

        // preload other bits, move indices away
        host_wr(16'h03D5, 8'hC6);
        host_wr(16'h03D4, 8'h11);
        host_wr(16'h03C4, 8'h03);

        // R7 / R9 / R10 modes
        set_mode(3'd1, n);
        chk("R10 busy cycles", n, 4);
        host_rd(16'h03C4, d); chk("R10 seq index after mode", d, 'h01);
        host_rd(16'h03D4, d); chk("R10 crtc index after mode", d, 'h34);
        host_rd(16'h03C5, s); host_rd(16'h03D5, c);
        chk("R7 standby seq", s, 'h7A); chk("R9 standby crtc", c, 'hC7);
        set_mode(3'd2, n);
        read_pair(s, c);
        chk("R7 suspend seq", s, 'h7A); chk("R9 suspend crtc", c, 'hE6);
        set_mode(3'd3, n);
        read_pair(s, c);
        chk("R7 off seq", s, 'h7A); chk("R9 off crtc", c, 'hE7);
        set_mode(3'd0, n);
        read_pair(s, c);
        chk("R7 on seq", s, 'h5A); chk("R9 on crtc", c, 'hC6);

        // R8 unknown codes act as On
        set_mode(3'd3, n);
        set_mode(3'd5, n);
        read_pair(s, c);
        chk("R8 code 5 seq", s, 'h5A); chk("R8 code 5 crtc", c, 'hC6);
        set_mode(3'd2, n);
        set_mode(3'd7, n);
        read_pair(s, c);
        chk("R8 code 7 crtc", c, 'hC6);

        // R11 ignored while busy
        @(negedge clk);
        pm_mode = 3'd3; pm_req = 1'b1;
        @(negedge clk);
        pm_req = 1'b0;
        bus_addr = 16'h03C5; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; pm_mode = 3'd0; pm_req = 1'b1;
        @(negedge clk);
        pm_req = 1'b0;
        while (pm_busy) @(negedge clk);
        chk("R11 no second request started", int'(pm_busy), 0);
        read_pair(s, c);
        chk("R11 seq unchanged by busy write", s, 'h7A);
        chk("R11 off mode kept", c, 'hE7);

        // R12 relocation and unmatched addresses
        io_base = 16'h03B0;
        host_rd(16'h03D5, d); chk("R12 old crtc port reads 0", d, 0);
        host_wr(16'h03D5, 8'h00);
        host_wr(16'h03B4, 8'h34);
        host_rd(16'h03B5, d); chk("R12 relocated crtc data", d, 'hE7);
        host_wr(16'h0123, 8'hFF);
        host_rd(16'h0123, d); chk("R12 unmatched address reads 0", d, 0);
        set_mode(3'd0, n);
        host_rd(16'h03B5, d); chk("R12 mode change at new base", d, 'hC6);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule